// File: doc/BRIEF.md
# ADC Result Register and Flag Unit

This block sits between the conversion sequencer of an analog-to-digital converter and the register bus. Each finished conversion arrives as a raw 8- or 10-bit code, a sequence position and a done strobe. The block turns the code into a 16-bit word, left- or right-justified and unsigned or two's complement, and stores it in one of eight result slots. Each slot has a conversion-complete flag.

Slot choice follows one of two mappings. In sequence-mapped mode the slot equals the conversion's position in the sequence. In FIFO mode a wrapping write pointer fills the slots one after another, and a sequence abort returns the pointer to slot 0. A status word holds a sequence-done flag, an overwrite flag and the write pointer. The sequence-done flag is cleared either by a write to the status word or, in fast-clear mode, by a read of any result. One interrupt request output follows the sequence-done flag when it is enabled.

Top module: `adc_result_unit`

## Requirements
- R1: With fifo_i low, an accepted conversion is stored in the slot numbered conv_pos_i.
- R2: With fifo_i high, results go to the slot given by a write pointer (status bits 4:2). The pointer advances by one per accepted conversion, wraps from 7 to 0, and returns to 0 on seq_abort_i. A conversion strobed in the same cycle as an abort is discarded.
- R3: Left-justified unsigned (right_i=0, sgn_i=0) places the code in the top bits of the word and fills the lower bits with zeros.
- R4: Right-justified unsigned (right_i=1, sgn_i=0) places the code in the low bits of the word and fills the upper bits with zeros.
- R5: Signed mode (sgn_i=1) inverts the code's MSB. In the right-justified layout the result is then sign-extended.
- R6: With res8_i high only conv_raw_i[7:0] is used, as an 8-bit code. With res8_i low all 10 bits are used.
- R7: The complete flag of a slot (address 9, bit n for slot n) sets when the slot is written and clears when the slot is read at address n (0..7). A write to the slot in the same cycle as the read wins.
- R8: The overwrite flag (status bit 1) sets when a slot is written while its complete flag is still set and is not being cleared in that cycle. Writing the status word (address 8) with bit 1 set clears it.
- R9: A conversion strobed with seq_last_i sets the sequence-done flag (status bit 0). With fast_clr_i low, writing the status word with bit 0 set clears it, and result reads leave it set.
- R10: With fast_clr_i high, any result read clears the sequence-done flag, and status writes leave it set.
- R11: irq_o is high exactly while the sequence-done flag and seq_ie_i are both high.
- R12: After reset all slots read 0 and all flags, the pointer and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| res8_i | input | 1 | 1: 8-bit codes, 0: 10-bit codes |
| right_i | input | 1 | 1: right-justified, 0: left-justified |
| sgn_i | input | 1 | 1: signed result, 0: unsigned |
| fifo_i | input | 1 | 1: FIFO slot mapping, 0: sequence mapping |
| fast_clr_i | input | 1 | 1: result read clears sequence-done flag |
| seq_ie_i | input | 1 | Sequence-done interrupt enable |
| seq_abort_i | input | 1 | Sequence abort; resets FIFO pointer |
| conv_done_i | input | 1 | Conversion done strobe |
| conv_pos_i | input | 3 | Sequence position of the conversion |
| conv_raw_i | input | 10 | Raw conversion code |
| seq_last_i | input | 1 | Conversion ends the sequence |
| bus_req_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1: write, 0: read |
| bus_addr_i | input | 4 | 0-7 result slots, 8 status, 9 complete flags |
| bus_wdata_i | input | 2 | Write-one-to-clear mask for status bits 1:0 |
| bus_rdata_o | output | 16 | Combinational read data |
| irq_o | output | 1 | Sequence-done interrupt request |

## Verification
A conversion strobe is captured at one rising edge, and its formatted word, flags and pointer show on bus_rdata_o right after that edge, because the read path is combinational. The flag side effects of a read or status write also take effect at the edge that ends the access. The bench drives every input at a falling edge. It samples read data one nanosecond later, before the edge that applies any clear, and reads flags back in the following access. So each check sees the state after exactly the edges it accounts for.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  localparam int STAT_SEQ_BIT = 0;
  localparam int STAT_OVR_BIT = 1;
  localparam int STAT_PTR_LSB = 2;
  localparam int SUB_STATUS   = 0;
  localparam int SUB_CCF      = 1;
endpackage

// File: rtl/adc_res_fmt.sv
module adc_res_fmt #(
  parameter int RAW_W  = 10,
  parameter int LO_W   = 8,
  parameter int WORD_W = 16
) (
  input  logic [RAW_W-1:0]  raw_i,
  input  logic              res8_i,
  input  logic              right_i,
  input  logic              sgn_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int HI_PAD = WORD_W - RAW_W;
  localparam int LO_PAD = WORD_W - LO_W;

  logic [RAW_W-1:0]  hi_v;
  logic [LO_W-1:0]   lo_v;
  logic [WORD_W-1:0] hi_w, lo_w;

  always_comb begin
    // offset binary -> two's complement by MSB flip
    hi_v = raw_i;
    hi_v[RAW_W-1] = raw_i[RAW_W-1] ^ sgn_i;
    lo_v = raw_i[LO_W-1:0];
    lo_v[LO_W-1] = raw_i[LO_W-1] ^ sgn_i;
    hi_w = right_i ? {{HI_PAD{sgn_i & hi_v[RAW_W-1]}}, hi_v}
                   : {hi_v, {HI_PAD{1'b0}}};
    lo_w = right_i ? {{LO_PAD{sgn_i & lo_v[LO_W-1]}}, lo_v}
                   : {lo_v, {LO_PAD{1'b0}}};
    word_o = res8_i ? lo_w : hi_w;
  end
endmodule

// File: rtl/adc_res_bank.sv
module adc_res_bank #(
  parameter int NUM_SLOTS = 8,
  parameter int WORD_W    = 16,
  parameter int SLOT_W    = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [SLOT_W-1:0]                 wr_slot_i,
  input  logic [WORD_W-1:0]                 wr_word_i,
  input  logic                              rd_clr_i,
  input  logic [SLOT_W-1:0]                 rd_slot_i,
  output logic [NUM_SLOTS-1:0][WORD_W-1:0]  word_o,
  output logic [NUM_SLOTS-1:0]              ccf_o,
  output logic                              unread_hit_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic wr_hit, rd_hit;
    assign wr_hit = wr_en_i  && (wr_slot_i == SLOT_W'(s));
    assign rd_hit = rd_clr_i && (rd_slot_i == SLOT_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_o[s] <= '0;
        ccf_o[s]  <= 1'b0;
      end else begin
        if (wr_hit) word_o[s] <= wr_word_i;
        if (wr_hit)      ccf_o[s] <= 1'b1;
        else if (rd_hit) ccf_o[s] <= 1'b0;
      end
    end
  end

  // flag still set and no read clearing it in this cycle
  assign unread_hit_o = wr_en_i && ccf_o[wr_slot_i] &&
                        !(rd_clr_i && (rd_slot_i == wr_slot_i));
endmodule

// File: rtl/adc_res_flags.sv
module adc_res_flags #(
  parameter int SLOT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_acc_i,
  input  logic              seq_last_i,
  input  logic              abort_i,
  input  logic              fifo_i,
  input  logic              fast_clr_i,
  input  logic              stat_wr_i,
  input  logic [1:0]        clr_mask_i,
  input  logic              res_rd_i,
  input  logic              unread_hit_i,
  output logic              seq_done_o,
  output logic              overrun_o,
  output logic [SLOT_W-1:0] ptr_o
);
  logic seq_set, seq_clr, ovr_clr;

  assign seq_set = wr_acc_i && seq_last_i;
  assign seq_clr = fast_clr_i ? res_rd_i : (stat_wr_i && clr_mask_i[0]);
  assign ovr_clr = stat_wr_i && clr_mask_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_done_o <= 1'b0;
      overrun_o  <= 1'b0;
      ptr_o      <= '0;
    end else begin
      seq_done_o <= seq_set || (seq_done_o && !seq_clr);
      overrun_o  <= unread_hit_i || (overrun_o && !ovr_clr);
      if (abort_i)                  ptr_o <= '0;
      else if (wr_acc_i && fifo_i)  ptr_o <= ptr_o + 1'b1;
    end
  end
endmodule

// File: rtl/adc_result_unit.sv
module adc_result_unit
  import adc_res_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int RAW_W     = 10,
  parameter int LO_W      = 8,
  parameter int WORD_W    = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int AW       = SLOT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res8_i,
  input  logic              right_i,
  input  logic              sgn_i,
  input  logic              fifo_i,
  input  logic              fast_clr_i,
  input  logic              seq_ie_i,
  input  logic              seq_abort_i,
  input  logic              conv_done_i,
  input  logic [SLOT_W-1:0] conv_pos_i,
  input  logic [RAW_W-1:0]  conv_raw_i,
  input  logic              seq_last_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [1:0]        bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic                             wr_acc;
  logic [SLOT_W-1:0]                slot_sel, wr_ptr_q, addr_slot;
  logic [WORD_W-1:0]                fmt_word;
  logic [NUM_SLOTS-1:0][WORD_W-1:0] slot_word;
  logic [NUM_SLOTS-1:0]             ccf_q;
  logic                             unread_hit, seq_done_q, overrun_q;
  logic                             res_sel, res_rd, stat_wr;

  assign wr_acc    = conv_done_i && !seq_abort_i;
  assign slot_sel  = fifo_i ? wr_ptr_q : conv_pos_i;
  assign addr_slot = bus_addr_i[SLOT_W-1:0];
  assign res_sel   = !bus_addr_i[AW-1];
  assign res_rd    = bus_req_i && !bus_we_i && res_sel;
  assign stat_wr   = bus_req_i && bus_we_i && !res_sel &&
                     (addr_slot == SLOT_W'(SUB_STATUS));

  adc_res_fmt #(.RAW_W(RAW_W), .LO_W(LO_W), .WORD_W(WORD_W)) u_fmt (
    .raw_i   (conv_raw_i),
    .res8_i  (res8_i),
    .right_i (right_i),
    .sgn_i   (sgn_i),
    .word_o  (fmt_word)
  );

  adc_res_bank #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_acc),
    .wr_slot_i    (slot_sel),
    .wr_word_i    (fmt_word),
    .rd_clr_i     (res_rd),
    .rd_slot_i    (addr_slot),
    .word_o       (slot_word),
    .ccf_o        (ccf_q),
    .unread_hit_o (unread_hit)
  );

  adc_res_flags #(.SLOT_W(SLOT_W)) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_acc_i     (wr_acc),
    .seq_last_i   (seq_last_i),
    .abort_i      (seq_abort_i),
    .fifo_i       (fifo_i),
    .fast_clr_i   (fast_clr_i),
    .stat_wr_i    (stat_wr),
    .clr_mask_i   (bus_wdata_i),
    .res_rd_i     (res_rd),
    .unread_hit_i (unread_hit),
    .seq_done_o   (seq_done_q),
    .overrun_o    (overrun_q),
    .ptr_o        (wr_ptr_q)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (res_sel) begin
      bus_rdata_o = slot_word[addr_slot];
    end else if (addr_slot == SLOT_W'(SUB_STATUS)) begin
      bus_rdata_o[STAT_SEQ_BIT] = seq_done_q;
      bus_rdata_o[STAT_OVR_BIT] = overrun_q;
      bus_rdata_o[STAT_PTR_LSB +: SLOT_W] = wr_ptr_q;
    end else if (addr_slot == SLOT_W'(SUB_CCF)) begin
      bus_rdata_o[NUM_SLOTS-1:0] = ccf_q;
    end
  end

  assign irq_o = seq_done_q && seq_ie_i;
endmodule

// File: rtl/adc_result_unit_chk.sv
module adc_result_unit_chk #(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int AW       = SLOT_W + 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 seq_abort_i,
  input logic                 seq_last_i,
  input logic                 seq_ie_i,
  input logic                 fast_clr_i,
  input logic                 bus_req_i,
  input logic                 bus_we_i,
  input logic [AW-1:0]        bus_addr_i,
  input logic [1:0]           bus_wdata_i,
  input logic                 irq_o,
  input logic                 wr_acc,
  input logic [SLOT_W-1:0]    slot_sel,
  input logic [NUM_SLOTS-1:0] ccf_q,
  input logic [SLOT_W-1:0]    wr_ptr_q,
  input logic                 seq_done_q,
  input logic                 overrun_q
);
  logic [SLOT_W-1:0] a_slot;
  logic rd_res, st_wr;
  assign a_slot = bus_addr_i[SLOT_W-1:0];
  assign rd_res = bus_req_i && !bus_we_i && !bus_addr_i[AW-1];
  assign st_wr  = bus_req_i && bus_we_i && bus_addr_i[AW-1] && (a_slot == '0);

  assert_ccf_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc |=> ccf_q[$past(slot_sel)]);

  assert_ccf_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_res && !(wr_acc && slot_sel == a_slot) |=> !ccf_q[$past(a_slot)]);

  assert_overwrite_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc && ccf_q[slot_sel] && !(rd_res && a_slot == slot_sel) |=> overrun_q);

  assert_ptr_abort_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_abort_i |=> wr_ptr_q == '0);

  assert_seq_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fast_clr_i && st_wr && bus_wdata_i[0] && !(wr_acc && seq_last_i) |=> !seq_done_q);

  assert_fast_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_clr_i && st_wr && seq_done_q |=> seq_done_q);

  assert_irq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc && seq_last_i && seq_ie_i && $stable(seq_ie_i) |=> irq_o);
endmodule

bind adc_result_unit adc_result_unit_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .seq_abort_i (seq_abort_i),
  .seq_last_i  (seq_last_i),
  .seq_ie_i    (seq_ie_i),
  .fast_clr_i  (fast_clr_i),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .wr_acc      (wr_acc),
  .slot_sel    (slot_sel),
  .ccf_q       (ccf_q),
  .wr_ptr_q    (wr_ptr_q),
  .seq_done_q  (seq_done_q),
  .overrun_q   (overrun_q)
);

// File: tb/adc_result_unit_test.sv
module adc_result_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic res8 = 0, right = 0, sgn = 0, fifo = 0, fast = 0, ie = 0, abort = 0;
  logic done = 0, last = 0;
  logic [2:0] pos = '0;
  logic [9:0] raw = '0;
  logic req = 0, we = 0;
  logic [3:0] addr = '0;
  logic [1:0] wdata = '0;
  logic [15:0] rdata;
  logic irq;
  int vectors = 0, miscompares = 0;
  logic [15:0] got;

  always #4 clk = ~clk;

  adc_result_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .res8_i(res8), .right_i(right), .sgn_i(sgn),
    .fifo_i(fifo), .fast_clr_i(fast), .seq_ie_i(ie), .seq_abort_i(abort),
    .conv_done_i(done), .conv_pos_i(pos), .conv_raw_i(raw), .seq_last_i(last),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  // {res8, right, sgn, raw[9:0], expected[15:0]}
  localparam logic [28:0] VEC [8] = '{
    {3'b000, 10'h3FF, 16'hFFC0},  // R3
    {3'b010, 10'h200, 16'h0200},  // R4
    {3'b011, 10'h200, 16'h0000},  // R5
    {3'b011, 10'h000, 16'hFE00},  // R5
    {3'b100, 10'h2AB, 16'hAB00},  // R6 upper bits ignored
    {3'b111, 10'h07F, 16'hFFFF},  // R6 R5
    {3'b101, 10'h081, 16'h0100},  // R6 R5
    {3'b001, 10'h155, 16'hD540}   // R5 R3
  };

  task automatic chk(input string req_tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [2:0] p, input logic [9:0] r, input logic l);
    @(negedge clk); done = 1; pos = p; raw = r; last = l;
    @(negedge clk); done = 0; last = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic wr_stat(input logic [1:0] m);
    @(negedge clk); req = 1; we = 1; addr = 4'h8; wdata = m;
    @(negedge clk); req = 0; we = 0; wdata = '0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    rd(4'h8, got); chk("R12 status", got, 16'h0000);
    rd(4'h9, got); chk("R12 ccf", got, 16'h0000);
    rd(4'h0, got); chk("R12 slot0", got, 16'h0000);
    chk("R12 irq", {15'b0, irq}, 16'h0000);

    // table: R1 slot by position, formatting R3-R6, flag set/clear R7
    for (int i = 0; i < 8; i++) begin
      {res8, right, sgn} = VEC[i][28:26];
      strobe(3'(i), VEC[i][25:16], 1'b0);
      rd(4'h9, got); chk("R7 ccf set", got, 16'(1 << i));
      rd(4'(i), got); chk("R1 format", got, VEC[i][15:0]);
      rd(4'h9, got); chk("R7 ccf clear", got, 16'h0000);
    end
    rd(4'h8, got); chk("R8 no overwrite", got, 16'h0000);

    // FIFO mapping R2, overwrite R8
    {res8, right, sgn} = 3'b010;
    fifo = 1;
    pulse_abort();
    for (int i = 0; i < 8; i++) strobe(3'd5, 10'(i + 1), 1'b0);
    rd(4'h8, got); chk("R2 ptr wrapped", got, 16'h0000);
    rd(4'h3, got); chk("R2 fifo slot3", got, 16'h0004);
    strobe(3'd5, 10'd9, 1'b0);
    rd(4'h8, got); chk("R8 overrun ptr1", got, 16'h0006);
    rd(4'h9, got); chk("R7 ccf fifo", got, 16'h00F7);
    rd(4'h0, got); chk("R2 wrap slot0", got, 16'h0009);
    // abort with strobe: discarded
    @(negedge clk); abort = 1; done = 1; raw = 10'd77;
    @(negedge clk); abort = 0; done = 0;
    rd(4'h8, got); chk("R2 abort ptr", got, 16'h0002);
    rd(4'h0, got); chk("R2 abort discard", got, 16'h0009);
    wr_stat(2'b10);
    rd(4'h8, got); chk("R8 overrun clear", got, 16'h0000);

    // sequence-done, normal clear R9, irq R11
    fifo = 0; fast = 0; ie = 1;
    strobe(3'd3, 10'h010, 1'b1);
    rd(4'h8, got); chk("R9 seq set", got, 16'h0001);
    chk("R11 irq high", {15'b0, irq}, 16'h0001);
    rd(4'h3, got); chk("R9 data", got, 16'h0010);
    rd(4'h8, got); chk("R9 read keeps", got, 16'h0001);
    wr_stat(2'b01);
    rd(4'h8, got); chk("R9 write clears", got, 16'h0000);
    chk("R11 irq low", {15'b0, irq}, 16'h0000);

    // fast clear R10
    fast = 1;
    strobe(3'd3, 10'h011, 1'b1);
    wr_stat(2'b01);
    rd(4'h8, got); chk("R10 write keeps", got, 16'h0001);
    rd(4'h3, got); chk("R10 data", got, 16'h0011);
    rd(4'h8, got); chk("R10 read clears", got, 16'h0000);
    chk("R11 irq after fast", {15'b0, irq}, 16'h0000);

    // disabled interrupt R11
    ie = 0;
    strobe(3'd0, 10'h001, 1'b1);
    rd(4'h8, got); chk("R11 flag set", got, 16'h0001);
    chk("R11 irq masked", {15'b0, irq}, 16'h0000);
    ie = 1; #1;
    chk("R11 irq enabled", {15'b0, irq}, 16'h0001);

    finish_run();
  end
endmodule